// File: doc/BRIEF.md
# Low-Power Clock Source Controller

This block chooses which of three clocks drives the internal processor clock and can stop that clock entirely for deep sleep. The candidates are the main input clock, a slow clock from a ring oscillator, and a PLL clock formed inside the block by halving the VCO input. The two analog oscillators and the PLL are not modelled: the block drives their power controls and receives their clocks.

Software programs the block through a write port clocked by an always-running control clock. The port holds two source-select bits, a PLL power bit, a main-oscillator power-down bit, a software halt bit and two wake-enable bits. Deep sleep starts when the halt bit is set or when the external halt pin is high. Software halt ends on reset or on an interrupt whose wake enable is set.

Each source has its own enable. The enable is brought into that source's domain through a synchronizer and takes effect on the source's falling edge. A source may be enabled only after every other source has gone fully idle. Source changes and sleep entry and exit therefore never produce a shortened pulse. When sleep is entered with the ring oscillator selected, the ring oscillator is powered down only after the block has confirmed that the clock output has stopped. On wake, the oscillator is powered up first, and the output resumes only after the restarted clock has carried the request through its synchronizer.

Top module: `clk_src_ctl`

## Requirements
- R1: During and after reset the output follows the main input clock, `pll_pwr` and `osc_pd` are 0, `asleep` is 0 and `ring_en` is 1.
- R2: A write (`wr_en` high at a `clk_ctl` rising edge) loads `wr_data`. The fields are: bit 0 slow select, bit 1 PLL select, bit 2 PLL power, bit 3 main oscillator power-down, bit 4 software halt, bit 5 `irq0` wake enable, bit 6 `irq1` wake enable. `pll_pwr` equals bit 2 and `osc_pd` equals bit 3 from that edge onwards.
- R3: When awake, the output runs from the slow clock if slow select is 1. Otherwise it runs from the VCO clock divided by two if PLL select is 1. Otherwise it runs from the main input clock.
- R4: At most one source is enabled onto the output at any time. Every high phase of `clk_core` equals a full high phase of one source, and no low phase is shorter than the shortest source half period.
- R5: Writing 1 to the software halt bit makes `asleep` 1 from that edge. The output then stops low.
- R6: `hw_halt` high makes `asleep` 1 after synchronization, and the output stops. After the pin is released the output resumes on the selected source.
- R7: `irq0` high with wake enable 0 set clears the software halt bit and the clock resumes. `irq0` high with that enable at 0 has no effect.
- R8: `irq1` high with wake enable 1 set clears the software halt bit and the clock resumes. `irq1` high with that enable at 0 has no effect.
- R9: `ring_en` is 0 only in deep sleep. When sleep is entered with the slow clock selected, the output has stopped before `ring_en` falls.
- R10: When the block wakes with the slow clock selected, `ring_en` rises first. The first output edge comes at least two slow half periods later.
- R11: Reset asserted during deep sleep clears the software halt, so `asleep` reads 0 and the main clock reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ctl | input | 1 | Always-running control clock |
| ck_main | input | 1 | Main input clock |
| ck_slow | input | 1 | Ring oscillator clock |
| ck_vco | input | 1 | PLL VCO clock |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 7 | Control write data |
| hw_halt | input | 1 | External halt pin, asynchronous |
| irq0 | input | 1 | Interrupt 0, asynchronous level |
| irq1 | input | 1 | Interrupt 1, asynchronous level |
| clk_core | output | 1 | Internal processor clock |
| ring_en | output | 1 | Ring oscillator power enable |
| pll_pwr | output | 1 | PLL power enable |
| osc_pd | output | 1 | Main oscillator power-down |
| asleep | output | 1 | Deep-sleep status |

## Verification
The bench builds the block with the default synchronizer depth `SYNC_LEN` = 2, which is the shortest depth that still gives a real two-flop crossing. At this depth every switch settles within a few hundred nanoseconds, so many randomly chosen source changes fit in one run. The source periods are 8 ns for main, 12 ns for the PLL (6 ns VCO) and 60 ns for slow. Because they differ, each high phase of the output identifies its source, and an edge count over a fixed window identifies the selected source. The ring oscillator model stops when `ring_en` is low, so the power-down ordering and the restart after wake are exercised as they would be on silicon.

// File: rtl/clk_src_ctl.sv
module clk_src_ctl #(
  parameter int SYNC_LEN = 2
) (
  input  logic       rst_n,
  input  logic       clk_ctl,
  input  logic       ck_main,
  input  logic       ck_slow,
  input  logic       ck_vco,
  input  logic       wr_en,
  input  logic [6:0] wr_data,
  input  logic       hw_halt,
  input  logic       irq0,
  input  logic       irq1,
  output logic       clk_core,
  output logic       ring_en,
  output logic       pll_pwr,
  output logic       osc_pd,
  output logic       asleep
);
  localparam int NSRC = 3;

  logic sel_slow, sel_pll, pll_on, main_off, sw_halt, w0_en, w1_en;
  logic [SYNC_LEN-1:0] halt_sh, i0_sh, i1_sh, sbusy_sh;
  logic halt_s, i0_s, i1_s, wake, sleep, pll_ck;
  logic [NSRC-1:0] src, tgt, gate, busy;

  assign halt_s = halt_sh[SYNC_LEN-1];
  assign i0_s   = i0_sh[SYNC_LEN-1];
  assign i1_s   = i1_sh[SYNC_LEN-1];
  assign wake   = (i0_s & w0_en) | (i1_s & w1_en);
  assign sleep  = sw_halt | halt_s;

  always_ff @(posedge clk_ctl or negedge rst_n)
    if (!rst_n) begin
      halt_sh  <= '0;
      i0_sh    <= '0;
      i1_sh    <= '0;
      sbusy_sh <= '0;
    end else begin
      halt_sh  <= {halt_sh[SYNC_LEN-2:0], hw_halt};
      i0_sh    <= {i0_sh[SYNC_LEN-2:0], irq0};
      i1_sh    <= {i1_sh[SYNC_LEN-2:0], irq1};
      sbusy_sh <= {sbusy_sh[SYNC_LEN-2:0], busy[1]};
    end

  always_ff @(posedge clk_ctl or negedge rst_n)
    if (!rst_n) begin
      sel_slow <= 1'b0;
      sel_pll  <= 1'b0;
      pll_on   <= 1'b0;
      main_off <= 1'b0;
      w0_en    <= 1'b0;
      w1_en    <= 1'b0;
      sw_halt  <= 1'b0;
    end else begin
      if (wr_en) begin
        sel_slow <= wr_data[0];
        sel_pll  <= wr_data[1];
        pll_on   <= wr_data[2];
        main_off <= wr_data[3];
        w0_en    <= wr_data[5];
        w1_en    <= wr_data[6];
      end
      if (wake)       sw_halt <= 1'b0;
      else if (wr_en) sw_halt <= wr_data[4];
    end

  assign pll_pwr = pll_on;
  assign osc_pd  = main_off;
  assign asleep  = sleep;
  assign ring_en = !(sleep && !sbusy_sh[SYNC_LEN-1]);

  assign tgt[0] = !sleep && !sel_slow && !sel_pll;
  assign tgt[1] = !sleep && sel_slow;
  assign tgt[2] = !sleep && !sel_slow && sel_pll;

  always_ff @(posedge ck_vco or negedge rst_n)
    if (!rst_n) pll_ck <= 1'b0;
    else        pll_ck <= !pll_ck;

  assign src = {pll_ck, ck_slow, ck_main};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic RV = (i == 0);
    logic [SYNC_LEN-1:0] rq_sh;
    logic req, g;
    assign req = tgt[i] && !(|(busy & ~(NSRC'(1) << i)));
    always_ff @(posedge src[i] or negedge rst_n)
      if (!rst_n) rq_sh <= {SYNC_LEN{RV}};
      else        rq_sh <= {rq_sh[SYNC_LEN-2:0], req};
    always_ff @(negedge src[i] or negedge rst_n)
      if (!rst_n) g <= RV;
      else        g <= rq_sh[SYNC_LEN-1];
    assign gate[i] = g;
    assign busy[i] = g | (|rq_sh);
  end

  assign clk_core = |(src & gate);

  // R4
  excl_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $onehot0(gate));

  // R9
  ring_order_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    !ring_en |-> (!gate[1] && sleep));

  // R2
  wr_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    wr_en |=> (pll_pwr == $past(wr_data[2]) && osc_pd == $past(wr_data[3])));

  // R5
  sw_halt_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (wr_en && wr_data[4] && !wake) |=> asleep);

  // R7 R8
  wake_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    wake |=> !sw_halt);
endmodule

// File: tb/clk_src_ctl_tb.sv
`timescale 1ns/100ps
module clk_src_ctl_tb_top;
  logic rst_n, clk_ctl, ck_main, ck_slow, ck_vco;
  logic wr_en, hw_halt, irq0, irq1;
  logic [6:0] wr_data;
  logic clk_core, ring_en, pll_pwr, osc_pd, asleep;

  int total = 0, bad = 0, edges = 0, glitch = 0, order_bad = 0;
  bit mon_on = 0, cur_slow = 0;
  realtime t_rise = 0, t_fall = 0;

  clk_src_ctl #(.SYNC_LEN(2)) dut_i (
    .rst_n(rst_n), .clk_ctl(clk_ctl), .ck_main(ck_main), .ck_slow(ck_slow),
    .ck_vco(ck_vco), .wr_en(wr_en), .wr_data(wr_data), .hw_halt(hw_halt),
    .irq0(irq0), .irq1(irq1), .clk_core(clk_core), .ring_en(ring_en),
    .pll_pwr(pll_pwr), .osc_pd(osc_pd), .asleep(asleep));

  initial begin clk_ctl = 0; forever #2.5 clk_ctl = !clk_ctl; end
  initial begin ck_main = 0; forever #4 ck_main = !ck_main; end
  initial begin ck_vco = 0; forever #3 ck_vco = !ck_vco; end
  initial begin
    ck_slow = 0;
    forever begin
      if (ring_en === 1'b1) begin #30 ck_slow = 1; #30 ck_slow = 0; end
      else #1;
    end
  end

  function automatic bit near(realtime a, real b);
    return (a > b - 0.05) && (a < b + 0.05);
  endfunction

  function automatic int exp_cnt(bit s, bit p, bit slp, int win);
    if (slp) return 0;
    return win / (s ? 60 : (p ? 12 : 8));
  endfunction

  always @(posedge clk_core) begin
    edges++;
    if (mon_on && ($realtime - t_fall) < 3.95) glitch++;
    if (mon_on && cur_slow && ring_en === 1'b0) order_bad++;
    t_rise = $realtime;
  end
  always @(negedge clk_core) begin
    if (mon_on && !(near($realtime - t_rise, 4) || near($realtime - t_rise, 6) ||
                    near($realtime - t_rise, 30))) glitch++;
    t_fall = $realtime;
  end
  always @(negedge ring_en)
    if (mon_on && clk_core !== 1'b0) order_bad++;

  task automatic chk(string req, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_cnt(string req, int act, int exp);
    chk(req, (act >= exp - 1) && (act <= exp + 1), act, exp);
  endtask

  task automatic wr(logic [6:0] d);
    @(negedge clk_ctl); wr_en = 1; wr_data = d;
    @(negedge clk_ctl); wr_en = 0;
  endtask

  task automatic count(int win, output int n);
    int e0;
    e0 = edges;
    #(win);
    n = edges - e0;
  endtask

  initial begin
    #900000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, seed;
    logic [6:0] d;
    realtime t_ring, t_clk;
    seed = $urandom(32'h5eed);
    rst_n = 1; wr_en = 0; wr_data = 0; hw_halt = 0; irq0 = 0; irq1 = 0;
    #3 rst_n = 0;
    #100;
    count(400, n); chk_cnt("R1 clock in reset", n, 50);
    @(negedge clk_ctl); rst_n = 1;
    @(negedge clk_ctl);
    chk("R1 pll_pwr", pll_pwr == 0, pll_pwr, 0);
    chk("R1 osc_pd", osc_pd == 0, osc_pd, 0);
    chk("R1 asleep", asleep == 0, asleep, 0);
    chk("R1 ring_en", ring_en == 1, ring_en, 1);
    #50 mon_on = 1;
    count(1200, n); chk_cnt("R1 main after reset", n, 150);

    wr(7'b0000011); cur_slow = 1;
    #800 count(1200, n); chk_cnt("R3 slow over pll", n, 20);
    wr(7'b0000110); cur_slow = 0;
    chk("R2 pll_pwr", pll_pwr == 1, pll_pwr, 1);
    #800 count(1200, n); chk_cnt("R3 pll", n, 100);

    for (int k = 0; k < 16; k++) begin
      d = 7'($urandom) & 7'b0001111;
      wr(d); cur_slow = d[0];
      chk("R2 pll_pwr rand", pll_pwr == d[2], pll_pwr, d[2]);
      chk("R2 osc_pd rand", osc_pd == d[3], osc_pd, d[3]);
      #800 count(1200, n);
      chk_cnt("R3 rand", n, exp_cnt(d[0], d[1], 0, 1200));
    end

    wr(7'b0000000); cur_slow = 0; #800;
    wr(7'b0010000);
    chk("R5 asleep", asleep == 1, asleep, 1);
    #600 count(600, n); chk_cnt("R5 stopped", n, 0);
    chk("R5 low", clk_core == 0, clk_core, 0);

    @(negedge clk_ctl) irq1 = 1;
    repeat (6) @(negedge clk_ctl);
    irq1 = 0;
    chk("R8 ignored when disabled", asleep == 1, asleep, 1);
    count(400, n); chk_cnt("R8 ignored clock", n, 0);

    wr(7'b0110000);
    @(negedge clk_ctl) irq0 = 1;
    repeat (4) @(negedge clk_ctl);
    chk("R7 wake", asleep == 0, asleep, 0);
    irq0 = 0;
    #600 count(1200, n); chk_cnt("R7 resumed", n, 150);

    wr(7'b1010000);
    chk("R8 asleep", asleep == 1, asleep, 1);
    @(negedge clk_ctl) irq0 = 1;
    repeat (6) @(negedge clk_ctl);
    irq0 = 0;
    chk("R7 ignored when disabled", asleep == 1, asleep, 1);
    @(negedge clk_ctl) irq1 = 1;
    repeat (4) @(negedge clk_ctl);
    chk("R8 wake", asleep == 0, asleep, 0);
    irq1 = 0;
    #600 count(1200, n); chk_cnt("R8 resumed", n, 150);

    wr(7'b0000001); cur_slow = 1;
    #800 count(1200, n); chk_cnt("R9 slow before sleep", n, 20);
    chk("R9 ring on awake", ring_en == 1, ring_en, 1);
    wr(7'b0010001);
    #600;
    chk("R9 ring off", ring_en == 0, ring_en, 0);
    count(600, n); chk_cnt("R9 stopped", n, 0);
    wr(7'b0110001);
    @(negedge clk_ctl) irq0 = 1;
    @(posedge ring_en); t_ring = $realtime;
    @(posedge clk_core); t_clk = $realtime;
    @(negedge clk_ctl) irq0 = 0;
    chk("R10 ring first", (t_clk - t_ring) >= 60, int'(t_clk - t_ring), 60);
    #200 count(1200, n); chk_cnt("R10 slow resumed", n, 20);
    chk("R9 order", order_bad == 0, order_bad, 0);

    wr(7'b0000000); cur_slow = 0; #800;
    @(negedge clk_ctl) hw_halt = 1;
    repeat (4) @(negedge clk_ctl);
    chk("R6 asleep", asleep == 1, asleep, 1);
    #600 count(600, n); chk_cnt("R6 stopped", n, 0);
    @(negedge clk_ctl) hw_halt = 0;
    repeat (4) @(negedge clk_ctl);
    chk("R6 awake", asleep == 0, asleep, 0);
    #600 count(1200, n); chk_cnt("R6 resumed", n, 150);

    wr(7'b0010000);
    #400 mon_on = 0;
    @(negedge clk_ctl) rst_n = 0;
    #1 chk("R11 asleep cleared", asleep == 0, asleep, 0);
    #100 count(400, n); chk_cnt("R11 clock in reset", n, 50);
    @(negedge clk_ctl) rst_n = 1;
    @(negedge clk_ctl);
    chk("R11 asleep after", asleep == 0, asleep, 0);

    chk("R4 pulse widths", glitch == 0, glitch, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule